// File: doc/BRIEF.md
# Write-Only Serial Control Receiver for an Audio Mixer

This block is a two-wire serial slave that only accepts writes. It sets the control fields of a small audio mixer: power and headphone configuration, the output routing mode, the output stage gains, and three input volumes. SCL and SDA are sampled by a fast system clock. The block finds START and STOP conditions, receives a fixed 7-bit device address followed by a write direction bit, and acknowledges by pulling SDA low. One data byte follows. That byte is acknowledged too and decoded into a register update.

The block has no register-address byte. The leading bits of the single data byte pick the target register, and the remaining bits carry its value. After the second acknowledge the block waits for STOP and answers nothing more. Read requests, other addresses and unused prefixes leave every field as it was. An external low-supply indication clears all fields unless software has turned that clearing off through a shutdown-register bit.

Top module: `audio_ctl_i2c_rx`

## Requirements
- R1: After a synchronous active-low reset, every register field is 0 and `sda_pull_o` is 0.
- R2: For a START followed by address 1111100 and R/W = 0 (byte 0xF8, MSB first), `sda_pull_o` is 1 while SCL is high during the ninth clock.
- R3: A non-matching address, or the matching address with R/W = 1, gets no acknowledge on the ninth clock or on the following byte, and changes no field.
- R4: After an accepted address, the 8-bit data byte is acknowledged on its ninth clock. Any further byte before STOP is not acknowledged and changes nothing.
- R5: A data byte with bits 7..5 = 000 loads the shutdown fields: bit 4 to `hp_capless_o`, bit 3 to `hp_bridge_o`, bit 2 to `supply_rst_dis_o`, bit 1 to `turnon_slow_o`, bit 0 to `pwr_on_o`.
- R6: A data byte with bits 7..4 = 0100 loads bits 3..0 into `route_mode_o`.
- R7: A data byte with bits 7..4 = 1000 loads bit 3 into `spk_boost_o` and bits 2..0 into `hp_atten_o`.
- R8: A data byte with bits 7..5 = 101, 110 or 111 loads bits 4..0 into `vol_mono_o`, `vol_left_o` or `vol_right_o` respectively.
- R9: A data byte with prefix 001, 011, 0101, 0110, 0111 or 1001 is acknowledged and changes no field.
- R10: While `supply_low_i` is 1 and `supply_rst_dis_o` is 0, all fields are cleared to 0. While `supply_rst_dis_o` is 1, `supply_low_i` has no effect.
- R11: A START in the middle of a byte abandons the current transfer and restarts address reception, so a complete transfer that follows is accepted.
- R12: A STOP in the middle of a data byte returns the block to idle without changing any field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| supply_low_i | input | 1 | External low-supply indication, asynchronous |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| hp_capless_o | output | 1 | Headphone capacitor-less (1) or coupled (0) mode |
| hp_bridge_o | output | 1 | Headphone bridged mono (1) or stereo (0) |
| supply_rst_dis_o | output | 1 | 1 disables clearing on low supply |
| turnon_slow_o | output | 1 | Turn-on time select |
| pwr_on_o | output | 1 | Device enable |
| route_mode_o | output | 4 | Output routing mode |
| spk_boost_o | output | 1 | Speaker output gain select |
| hp_atten_o | output | 3 | Headphone attenuation step |
| vol_mono_o | output | 5 | Mono input volume step |
| vol_left_o | output | 5 | Left input volume step |
| vol_right_o | output | 5 | Right input volume step |

## Verification
The hardest situations to reach are bus conditions that interrupt a byte partway through. These are a START after a few address or data bits, and a STOP before the data byte is complete. The bench reaches them with bit-level tasks that can stop a byte after any bit count and then issue START or STOP while SCL is high. It then checks that the interrupted byte left no trace and that the next full transfer is accepted. Low-supply pulses are mixed into random traffic while the clear-disable bit is in either state.

// File: rtl/actl_pkg.sv
// Shared constants and types for the audio control receiver.
// Assumes an 8-bit frame: a 7-bit address plus direction bit, then one data byte.
package actl_pkg;
    localparam int          BYTE_W    = 8;
    localparam int          CNT_W     = 4;
    localparam int          ADDR_W    = 7;
    localparam logic [ADDR_W-1:0] DEV_ADDR = 7'b1111100;
    localparam int          SHDN_W    = 5;
    localparam int          MODE_W    = 4;
    localparam int          GAIN_W    = 4;
    localparam int          VOL_W     = 5;
    localparam int          N_VOL     = 3;
    localparam int          VOL_BASE  = 5;   // mono=101, left=110, right=111
    localparam int          FIELDS_W  = SHDN_W + MODE_W + GAIN_W + N_VOL*VOL_W;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_DATA, ST_DATA_ACK, ST_HOLD, ST_SKIP
    } rx_state_t;
endpackage

// File: rtl/actl_line_sync.sv
// Brings SCL, SDA and the low-supply flag into the clock domain and derives
// one-cycle pulses for SCL edges, START and STOP.
// Assumes clk is at least 16x the SCL rate so that no edge is missed.
module actl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic sup_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p,
    output logic sda_s,
    output logic sup_s
);
    logic [STAGES:0]   scl_sr;
    logic [STAGES:0]   sda_sr;
    logic [STAGES-1:0] sup_sr;
    logic scl_now, scl_old, sda_old;

    // Shift the raw lines through the synchronizer chain plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sr <= '1;
            sda_sr <= '1;
            sup_sr <= '0;
        end else begin
            scl_sr <= {scl_sr[STAGES-1:0], scl_i};
            sda_sr <= {sda_sr[STAGES-1:0], sda_i};
            sup_sr <= {sup_sr[STAGES-2:0], sup_i};
        end
    end

    assign scl_now  = scl_sr[STAGES-1];
    assign scl_old  = scl_sr[STAGES];
    assign sda_s    = sda_sr[STAGES-1];
    assign sda_old  = sda_sr[STAGES];
    assign sup_s    = sup_sr[STAGES-1];

    // Edge and bus-condition decode on synchronized values.
    always_comb begin
        scl_rise = scl_now & ~scl_old;
        scl_fall = ~scl_now & scl_old;
        start_p  = scl_now & scl_old & sda_old & ~sda_s;
        stop_p   = scl_now & scl_old & ~sda_old & sda_s;
    end
endmodule

// File: rtl/actl_byte_rx.sv
// Bus protocol engine: address match, acknowledge generation and capture of
// the single data byte. Emits a one-cycle write strobe at the start of the
// data acknowledge. Assumes synchronized, edge-decoded inputs.
module actl_byte_rx
    import actl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic              sda_s,
    output logic              pull,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_byte
);
    localparam logic [CNT_W-1:0]  FULL    = CNT_W'(BYTE_W);
    localparam logic [BYTE_W-1:0] ADDR_WR = {DEV_ADDR, 1'b0};

    rx_state_t         state;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;

    // Advance the transfer state on START, STOP and SCL edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            shreg  <= '0;
            bitcnt <= '0;
            wr_en  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (stop_p) begin
                state <= ST_IDLE;
            end else if (start_p) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
            end else begin
                case (state)
                    ST_ADDR, ST_DATA: begin
                        if (scl_rise && bitcnt < FULL) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == FULL) begin
                            if (state == ST_ADDR) begin
                                state <= (shreg == ADDR_WR) ? ST_ADDR_ACK : ST_SKIP;
                            end else begin
                                state <= ST_DATA_ACK;
                                wr_en <= 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            state  <= ST_DATA;
                            bitcnt <= '0;
                        end
                    end
                    ST_DATA_ACK: begin
                        if (scl_fall) state <= ST_HOLD;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign pull    = (state == ST_ADDR_ACK) || (state == ST_DATA_ACK);
    assign wr_byte = shreg;
endmodule

// File: rtl/actl_ctl_regs.sv
// Control register bank. Decodes the prefix of a written byte and updates the
// chosen register; a qualified low-supply flag clears everything.
// Assumes wr_en is a single-cycle strobe.
module actl_ctl_regs
    import actl_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [BYTE_W-1:0]           wr_byte,
    input  logic                        sup_low,
    output logic [SHDN_W-1:0]           shdn_o,
    output logic [MODE_W-1:0]           mode_o,
    output logic [GAIN_W-1:0]           gain_o,
    output logic [N_VOL-1:0][VOL_W-1:0] vol_o
);
    logic clr;
    assign clr = sup_low & ~shdn_o[2];

    // Shutdown, routing and gain registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            shdn_o <= '0;
            mode_o <= '0;
            gain_o <= '0;
        end else if (wr_en) begin
            if (wr_byte[7:5] == 3'b000)       shdn_o <= wr_byte[SHDN_W-1:0];
            else if (wr_byte[7:4] == 4'b0100) mode_o <= wr_byte[MODE_W-1:0];
            else if (wr_byte[7:4] == 4'b1000) gain_o <= wr_byte[GAIN_W-1:0];
        end
    end

    for (genvar g = 0; g < N_VOL; g++) begin : g_vol
        localparam logic [2:0] SEL = 3'(VOL_BASE + g);
        logic [VOL_W-1:0] q;
        // One volume register per input, selected by its 3-bit prefix.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)                    q <= '0;
            else if (wr_en && wr_byte[7:5] == SEL) q <= wr_byte[VOL_W-1:0];
        end
        assign vol_o[g] = q;
    end
endmodule

// File: rtl/audio_ctl_i2c_rx.sv
// Top level of the write-only serial control receiver. Ties the line
// synchronizer, protocol engine and register bank together and maps the
// register fields onto named outputs.
module audio_ctl_i2c_rx
    import actl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             supply_low_i,
    output logic             sda_pull_o,
    output logic             hp_capless_o,
    output logic             hp_bridge_o,
    output logic             supply_rst_dis_o,
    output logic             turnon_slow_o,
    output logic             pwr_on_o,
    output logic [MODE_W-1:0] route_mode_o,
    output logic             spk_boost_o,
    output logic [2:0]       hp_atten_o,
    output logic [VOL_W-1:0] vol_mono_o,
    output logic [VOL_W-1:0] vol_left_o,
    output logic [VOL_W-1:0] vol_right_o
);
    logic scl_rise, scl_fall, start_p, stop_p, sda_s, sup_low_s;
    logic wr_en;
    logic [BYTE_W-1:0]           wr_byte;
    logic [SHDN_W-1:0]           shdn;
    logic [GAIN_W-1:0]           gain;
    logic [N_VOL-1:0][VOL_W-1:0] vol;

    actl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sup_i(supply_low_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
        .sda_s(sda_s), .sup_s(sup_low_s)
    );

    actl_byte_rx u_rx (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_p(start_p), .stop_p(stop_p), .sda_s(sda_s),
        .pull(sda_pull_o), .wr_en(wr_en), .wr_byte(wr_byte)
    );

    actl_ctl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte), .sup_low(sup_low_s),
        .shdn_o(shdn), .mode_o(route_mode_o), .gain_o(gain), .vol_o(vol)
    );

    assign {hp_capless_o, hp_bridge_o, supply_rst_dis_o, turnon_slow_o, pwr_on_o} = shdn;
    assign spk_boost_o = gain[3];
    assign hp_atten_o  = gain[2:0];
    assign vol_mono_o  = vol[0];
    assign vol_left_o  = vol[1];
    assign vol_right_o = vol[2];
endmodule

// File: rtl/actl_ctl_checker.sv
// Protocol and register-bank properties for audio_ctl_i2c_rx, attached by bind.
// Assumes clk runs at least 16x SCL, so the acknowledge pull changes while SCL is low.
module actl_ctl_checker #(
    parameter int FW = 28
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_i,
    input logic          sda_pull,
    input logic          sup_low,
    input logic [FW-1:0] fields
);
    logic clear_now;
    assign clear_now = sup_low && !fields[FW-3];

    AST_ACK_BEGINS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_i);  // R2
    AST_ACK_ENDS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull) |-> !scl_i);  // R4
    AST_SUPPLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clear_now |=> (fields == '0));  // R10
    AST_UPDATE_ONLY_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(fields) && !$past(clear_now)) |-> sda_pull);  // R9
endmodule

bind audio_ctl_i2c_rx actl_ctl_checker #(.FW(actl_pkg::FIELDS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull(sda_pull_o), .sup_low(sup_low_s),
    .fields({hp_capless_o, hp_bridge_o, supply_rst_dis_o, turnon_slow_o, pwr_on_o,
             route_mode_o, spk_boost_o, hp_atten_o, vol_mono_o, vol_left_o, vol_right_o})
);

// File: tb/audio_ctl_i2c_rx_tb.sv
module audio_ctl_i2c_rx_tb;
    localparam int Q = 8;                 // quarter SCL period in clk cycles
    localparam logic [6:0] DEV = 7'b1111100;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1, sup_low = 1'b0;
    logic sda_pull_o;
    logic hp_capless_o, hp_bridge_o, supply_rst_dis_o, turnon_slow_o, pwr_on_o, spk_boost_o;
    logic [3:0] route_mode_o;
    logic [2:0] hp_atten_o;
    logic [4:0] vol_mono_o, vol_left_o, vol_right_o;
    wire  sda_line = sda_m & ~sda_pull_o;

    int errors = 0, checks = 0;
    bit done = 0;
    logic [27:0] exp_f = '0;

    always #2.5 clk = ~clk;

    audio_ctl_i2c_rx u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .supply_low_i(sup_low),
        .sda_pull_o(sda_pull_o), .hp_capless_o(hp_capless_o), .hp_bridge_o(hp_bridge_o),
        .supply_rst_dis_o(supply_rst_dis_o), .turnon_slow_o(turnon_slow_o), .pwr_on_o(pwr_on_o),
        .route_mode_o(route_mode_o), .spk_boost_o(spk_boost_o), .hp_atten_o(hp_atten_o),
        .vol_mono_o(vol_mono_o), .vol_left_o(vol_left_o), .vol_right_o(vol_right_o)
    );

    function automatic logic [27:0] actual();
        return {hp_capless_o, hp_bridge_o, supply_rst_dis_o, turnon_slow_o, pwr_on_o,
                route_mode_o, spk_boost_o, hp_atten_o, vol_mono_o, vol_left_o, vol_right_o};
    endfunction

    // Expected register image after a written byte, from the prefix rules.
    function automatic logic [27:0] apply(input logic [27:0] f, input logic [7:0] b);
        logic [27:0] r = f;
        if (b[7:5] == 3'b000)       r[27:23] = b[4:0];
        else if (b[7:4] == 4'b0100) r[22:19] = b[3:0];
        else if (b[7:4] == 4'b1000) r[18:15] = b[3:0];
        else if (b[7:5] == 3'b101)  r[14:10] = b[4:0];
        else if (b[7:5] == 3'b110)  r[9:5]   = b[4:0];
        else if (b[7:5] == 3'b111)  r[4:0]   = b[4:0];
        return r;
    endfunction

    function automatic string tag_of(input logic [7:0] b);
        if (b[7:5] == 3'b000) return "R5";
        if (b[7:4] == 4'b0100) return "R6";
        if (b[7:4] == 4'b1000) return "R7";
        if (b[7] && b[6:5] != 2'b00) return "R8";
        return "R9";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(Q/2); scl = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl = 1'b0; wt(Q/2);
    endtask

    task automatic bus_stop();
        wt(Q); sda_m = 1'b0; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
    endtask

    task automatic send_bit(input logic b);
        wt(Q); sda_m = b; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        wt(Q); sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); ack = sda_pull_o; wt(Q); scl = 1'b0;
    endtask

    // Full two-byte write; checks both acknowledges and the resulting fields.
    task automatic do_write(input logic [6:0] a, input logic rw, input logic [7:0] d);
        logic ack1, ack2, ok;
        ok = (a == DEV) && !rw;
        bus_start();
        send_byte({a, rw}, ack1);
        check(ok ? "R2 address ack" : "R3 address nack", 32'(ack1), 32'(ok));
        send_byte(d, ack2);
        check(ok ? "R4 data ack" : "R3 data nack", 32'(ack2), 32'(ok));
        bus_stop();
        if (ok) exp_f = apply(exp_f, d);
        wt(4);
        check(ok ? tag_of(d) : "R3 fields kept", 32'(actual()), 32'(exp_f));
    endtask

    task automatic supply_pulse();
        sup_low = 1'b1; wt(6); sup_low = 1'b0; wt(6);
        if (!exp_f[25]) exp_f = '0;
        check("R10 supply low", 32'(actual()), 32'(exp_f));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic a1, a2;
        void'($urandom(32'd4517));
        wt(5); rst_n = 1'b1; wt(3);
        check("R1 reset fields", 32'(actual()), 32'h0);
        check("R1 reset pull", 32'(sda_pull_o), 32'h0);

        // Directed: each register and unused prefixes.
        do_write(DEV, 1'b0, 8'h4A);     // R6
        do_write(DEV, 1'b0, 8'h8B);     // R7
        do_write(DEV, 1'b0, 8'hB3);     // R8 mono
        do_write(DEV, 1'b0, 8'hC7);     // R8 left
        do_write(DEV, 1'b0, 8'hFE);     // R8 right
        do_write(DEV, 1'b0, 8'h3F);     // R9
        do_write(DEV, 1'b0, 8'h6F);     // R9
        do_write(DEV, 1'b0, 8'h5A);     // R9
        do_write(DEV, 1'b0, 8'h9F);     // R9
        do_write(DEV, 1'b1, 8'h41);     // R3 read request
        do_write(7'b1111101, 1'b0, 8'h42); // R3 wrong address
        do_write(DEV, 1'b0, 8'h15);     // R5, clear disabled
        supply_pulse();                 // R10 ignored
        do_write(DEV, 1'b0, 8'h01);     // R5, clear enabled
        supply_pulse();                 // R10 clears

        // R11: repeated START in the middle of the address byte.
        bus_start();
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_start();
        send_byte({DEV, 1'b0}, a1);
        send_byte(8'h4F, a2);
        bus_stop(); wt(4);
        exp_f = apply(exp_f, 8'h4F);
        check("R11 restart ack", 32'({a1, a2}), 32'h3);
        check("R11 restart fields", 32'(actual()), 32'(exp_f));

        // R11: repeated START in the middle of the data byte.
        bus_start();
        send_byte({DEV, 1'b0}, a1);
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        bus_start();
        send_byte({DEV, 1'b0}, a1);
        send_byte(8'hC9, a2);
        bus_stop(); wt(4);
        exp_f = apply(exp_f, 8'hC9);
        check("R11 data restart", 32'(actual()), 32'(exp_f));

        // R12: STOP in the middle of the data byte.
        bus_start();
        send_byte({DEV, 1'b0}, a1);
        for (int i = 0; i < 5; i++) send_bit(i[0]);
        bus_stop(); wt(4);
        check("R12 stop mid byte", 32'(actual()), 32'(exp_f));
        do_write(DEV, 1'b0, 8'h87);     // R12 idle again, R7

        // R4: a third byte before STOP is not acknowledged.
        bus_start();
        send_byte({DEV, 1'b0}, a1);
        send_byte(8'hA4, a2);
        exp_f = apply(exp_f, 8'hA4);
        send_byte(8'hA9, a1);
        check("R4 extra byte nack", 32'(a1), 32'h0);
        bus_stop(); wt(4);
        check("R4 extra byte ignored", 32'(actual()), 32'(exp_f));

        // Random traffic with occasional bad address and supply pulses.
        for (int n = 0; n < 120; n++) begin
            logic [7:0] d;
            int sel;
            d   = 8'($urandom);
            sel = int'($urandom % 16);
            if (sel == 0)      do_write(DEV, 1'b1, d);
            else if (sel == 1) do_write(7'($urandom) | 7'h01, 1'b0, d);
            else if (sel == 2) supply_pulse();
            else               do_write(DEV, 1'b0, d);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule